// File: doc/BRIEF.md
# Column packet decoder with posted-write buffer

This block receives the column half of a high-speed memory device's control channel. Five control pins are sampled once per bit time; the block's clock `clk` runs at that bit rate, so one tick per interface clock edge. A logic one on pin 0 while the block is idle opens a 40-bit packet spanning eight ticks. The first 23 bits form a column command: device address, bank, column and a 4-bit opcode. The remaining 17 bits are either a pair of byte masks or an extended command with its own device, bank and opcode.

Each packet is checked against the 5-bit `dev_id`. It raises one-tick strobes for read, precharge, extended precharge, current calibration, calibration sampling and relax to standby. Writes are posted into a single-entry buffer holding the 16-byte data word, bank, column and an auto-precharge flag. A later packet retires the buffer through a sense-amp write port with a per-byte enable mask. That packet may be addressed to this device or to another one. Reads to this device never retire the buffer, which keeps the internal data path free for the read.

Packets are honoured only while `attn` is high, meaning the device is in its attention power state. Packets that arrive otherwise are framed and then discarded.

Top module: `col_pkt_engine`

## Requirements
- R1: Framing and timing. With the framer idle, a 1 on `col_in[0]` starts a packet. Tick k (0..7) of the packet is stored at packet bits [5k+4:5k], with `col_in[p]` at bit 5k+p. Pin 0 is not examined for a new start until all eight ticks are stored. The packet's strobes are high for exactly one tick, the tick after the ninth rising edge counted from the start tick.
- R2: When the column device field (bits [5:1]) equals `dev_id` and the opcode (bits [20:17]) has low bits 11 (read, or read with auto-precharge), `rd_stb` rises. `rd_bank` is taken from bits [10:6] and `rd_col` from bits [16:11]. No retire happens.
- R3: A packet whose column device field differs from `dev_id` retires this device's buffer.
- R4: A matched write (opcode low bits 001 or 101) first retires the old buffer content on the `ret_*` outputs. It then loads `wdata`, the bank and the column. `wdata` is sampled on the rising edge that follows the packet's last tick.
- R5: A retire with the buffer empty gives no `ret_stb`. Reset empties the buffer and clears every output.
- R6: Bit 23 set selects a mask packet. The retire mask is then bits [31:24] for lane A (`ret_data[63:0]`) and bits [39:32] for lane B (`ret_data[127:64]`). Mask bit i enables byte i of its lane, bit 0 being the earliest byte. With bit 23 clear, the retire mask is all ones.
- R7: A matched opcode x100 retires the buffer and raises `pre_stb` with the column bank. A matched x111 raises `rd_stb` and `pre_stb` together for the same bank.
- R8: A buffer entry loaded by write with auto-precharge (x101) raises `ret_pre` together with `ret_stb` when it retires. `ret_bank` names the bank to close.
- R9: With bit 23 clear, the extended device field is [28:24], the bank field [33:29] and the opcode field [38:34]. When the device field equals `dev_id` and opcode bit 0 is clear, the block decodes the opcode as follows. Bit 4 raises `xpre_stb` with `xpre_bank`. Bit 3 raises `cal_stb`. Bits 3 and 2 together also raise `sam_stb`. Bit 1 raises `relax_stb`. These effects combine. An opcode with bit 0 set does nothing.
- R10: Column opcode bit 3 on a matched packet raises `relax_stb` in addition to the command in the low three bits.
- R11: A packet completed while `attn` is low at the decode edge has no effect. It gives no strobe, performs no retire and loads nothing.
- R12: Matched reserved column opcodes (low bits 010 and 110) raise no strobe of their own but still retire the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one tick per interface clock edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| col_in | input | 5 | Column control pins, one sample per tick |
| attn | input | 1 | Device is in the attention power state |
| dev_id | input | 5 | This device's address on the channel |
| wdata | input | 128 | Write data word, lane A in [63:0], lane B in [127:64] |
| rd_stb | output | 1 | Read column strobe |
| rd_bank | output | 5 | Bank of the read |
| rd_col | output | 6 | Column of the read |
| pre_stb | output | 1 | Precharge request from the column command |
| pre_bank | output | 5 | Bank to precharge from the column command |
| xpre_stb | output | 1 | Precharge request from the extended command |
| xpre_bank | output | 5 | Bank to precharge from the extended command |
| ret_stb | output | 1 | Sense-amp write of the retired buffer entry |
| ret_bank | output | 5 | Bank of the retired entry |
| ret_col | output | 6 | Column of the retired entry |
| ret_data | output | 128 | Data of the retired entry |
| ret_mask | output | 16 | Byte enables for the retired entry |
| ret_pre | output | 1 | Precharge `ret_bank` after this retire |
| cal_stb | output | 1 | Drive output current calibration |
| sam_stb | output | 1 | Sample the calibrated current |
| relax_stb | output | 1 | Move to the standby power state |

## Verification
The bench targets the ordering inside a write. If the new word were loaded before the old one left, the retire port would show the new data and the old write would be lost. It checks that a read to this device leaves the buffer intact, while a read aimed at another device drains it; getting that the wrong way round loses data or stalls posted writes. It exercises a mask packet arriving one packet after its write; a design that applied masks only on the write packet itself would write every byte. It also places bank bits holding a 1 on pin 0 inside a packet, exposes packets sent outside the attention state, and pulses reset with a full buffer. A design that re-framed on those bits, or ignored the power gate or the reset, would retire stale or phantom writes.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
   // Packet geometry (fixed by the channel format)
   localparam int PKT_W    = 40;
   localparam int DEV_W    = 5;
   localparam int BANK_W   = 5;
   localparam int COL_W    = 6;
   localparam int OP_W     = 4;
   localparam int XOP_W    = 5;
   localparam int MASK_W   = 16;

   // Field offsets inside the 40-bit packet
   localparam int START_POS = 0;
   localparam int DEV_LO    = 1;
   localparam int BANK_LO   = 6;
   localparam int COL_LO    = 11;
   localparam int OP_LO     = 17;
   localparam int RSV_LO    = 21;
   localparam int MSEL_POS  = 23;
   localparam int TAIL_LO   = 24;
   localparam int XDEV_LO   = 24;
   localparam int XBANK_LO  = 29;
   localparam int XOP_LO    = 34;

   typedef struct packed {
      logic                rd;
      logic                cpre;
      logic                xpre;
      logic                retire;
      logic                load;
      logic                autopre;
      logic                cal;
      logic                sam;
      logic                relax;
      logic [BANK_W-1:0]   bank;
      logic [COL_W-1:0]    col;
      logic [BANK_W-1:0]   xbank;
      logic [MASK_W-1:0]   mask;
   } dec_t;
endpackage

// File: rtl/cpe_framer.sv
module cpe_framer #(
   parameter int PINS  = 5,
   parameter int SLOTS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PINS-1:0]       col_in,
   output logic [PINS*SLOTS-1:0] pkt,
   output logic                  pkt_done
);
   localparam int PKT   = PINS * SLOTS;
   localparam int CNT_W = (SLOTS > 2) ? $clog2(SLOTS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic             start;
   logic [PKT-1:0]   pkt_q;

   assign start = !busy && col_in[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         pkt_done <= 1'b0;
      end else begin
         pkt_done <= busy && (cnt == LAST);
         if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(1);
         end else if (busy) begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               cnt  <= '0;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic take;
      if (s == 0) begin : g_first
         assign take = start;
      end else begin : g_rest
         assign take = busy && (cnt == CNT_W'(s));
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    pkt_q[s*PINS +: PINS] <= '0;
         else if (take) pkt_q[s*PINS +: PINS] <= col_in;
      end
   end

   assign pkt = pkt_q;
endmodule

// File: rtl/cpe_decode.sv
module cpe_decode
   import cpe_pkg::*;
#(
   parameter int LANES      = 2,
   parameter int LANE_BYTES = 8
) (
   input  logic [PKT_W-1:0] pkt,
   input  logic             pkt_done,
   input  logic             attn,
   input  logic [DEV_W-1:0] dev_id,
   output dec_t             dec
);
   logic [DEV_W-1:0]  c_dev, x_dev;
   logic [BANK_W-1:0] c_bank, x_bank;
   logic [COL_W-1:0]  c_col;
   logic [OP_W-1:0]   c_op;
   logic [XOP_W-1:0]  x_op;
   logic              m_sel;
   logic [MASK_W-1:0] lane_mask;
   logic              fire, c_match, x_match, c_read;
   logic              unused_rsv;

   assign c_dev  = pkt[DEV_LO   +: DEV_W];
   assign c_bank = pkt[BANK_LO  +: BANK_W];
   assign c_col  = pkt[COL_LO   +: COL_W];
   assign c_op   = pkt[OP_LO    +: OP_W];
   assign m_sel  = pkt[MSEL_POS];
   assign x_dev  = pkt[XDEV_LO  +: DEV_W];
   assign x_bank = pkt[XBANK_LO +: BANK_W];
   assign x_op   = pkt[XOP_LO   +: XOP_W];
   assign unused_rsv = ^{pkt[START_POS], pkt[RSV_LO +: 2]};

   // per-lane byte enables: explicit mask packet or write-all
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_mask[l*LANE_BYTES +: LANE_BYTES] =
         m_sel ? pkt[TAIL_LO + l*LANE_BYTES +: LANE_BYTES] : {LANE_BYTES{1'b1}};
   end

   assign fire    = pkt_done && attn;
   assign c_match = (c_dev == dev_id);
   assign c_read  = c_match && (c_op[1:0] == 2'b11);
   assign x_match = !m_sel && (x_dev == dev_id) && !x_op[0];

   always_comb begin
      dec         = '0;
      dec.rd      = fire && c_read;
      dec.retire  = fire && !c_read;
      dec.load    = fire && c_match && (c_op[1:0] == 2'b01);
      dec.autopre = c_op[2];
      dec.cpre    = fire && c_match &&
                    ((c_op[2:0] == 3'b100) || (c_op[2:0] == 3'b111));
      dec.xpre    = fire && x_match && x_op[4];
      dec.cal     = fire && x_match && x_op[3];
      dec.sam     = fire && x_match && x_op[3] && x_op[2];
      dec.relax   = fire && ((c_match && c_op[3]) || (x_match && x_op[1]));
      dec.bank    = c_bank;
      dec.col     = c_col;
      dec.xbank   = x_bank;
      dec.mask    = lane_mask;
   end
endmodule

// File: rtl/cpe_wbuf.sv
module cpe_wbuf #(
   parameter int DATA_W = 128,
   parameter int MASK_W = 16,
   parameter int BANK_W = 5,
   parameter int COL_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire,
   input  logic              load,
   input  logic              autopre,
   input  logic [BANK_W-1:0] bank,
   input  logic [COL_W-1:0]  col,
   input  logic [MASK_W-1:0] mask,
   input  logic [DATA_W-1:0] wdata,
   output logic              ret_stb,
   output logic              ret_pre,
   output logic [BANK_W-1:0] ret_bank,
   output logic [COL_W-1:0]  ret_col,
   output logic [DATA_W-1:0] ret_data,
   output logic [MASK_W-1:0] ret_mask
);
   logic              vld;
   logic              b_auto;
   logic [BANK_W-1:0] b_bank;
   logic [COL_W-1:0]  b_col;
   logic [DATA_W-1:0] b_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld      <= 1'b0;
         b_auto   <= 1'b0;
         b_bank   <= '0;
         b_col    <= '0;
         b_data   <= '0;
         ret_stb  <= 1'b0;
         ret_pre  <= 1'b0;
         ret_bank <= '0;
         ret_col  <= '0;
         ret_data <= '0;
         ret_mask <= '0;
      end else begin
         // old entry leaves before a new one is taken
         ret_stb  <= retire && vld;
         ret_pre  <= retire && vld && b_auto;
         ret_bank <= b_bank;
         ret_col  <= b_col;
         ret_data <= b_data;
         ret_mask <= mask;
         if (load) begin
            vld    <= 1'b1;
            b_auto <= autopre;
            b_bank <= bank;
            b_col  <= col;
            b_data <= wdata;
         end else if (retire) begin
            vld <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/col_pkt_engine.sv
module col_pkt_engine
   import cpe_pkg::*;
#(
   parameter int PINS       = 5,
   parameter int SLOTS      = 8,
   parameter int LANES      = 2,
   parameter int LANE_BYTES = 8,
   parameter int DATA_W     = LANES * LANE_BYTES * 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PINS-1:0]         col_in,
   input  logic                    attn,
   input  logic [DEV_W-1:0]        dev_id,
   input  logic [DATA_W-1:0]       wdata,
   output logic                    rd_stb,
   output logic [BANK_W-1:0]       rd_bank,
   output logic [COL_W-1:0]        rd_col,
   output logic                    pre_stb,
   output logic [BANK_W-1:0]       pre_bank,
   output logic                    xpre_stb,
   output logic [BANK_W-1:0]       xpre_bank,
   output logic                    ret_stb,
   output logic [BANK_W-1:0]       ret_bank,
   output logic [COL_W-1:0]        ret_col,
   output logic [DATA_W-1:0]       ret_data,
   output logic [LANES*LANE_BYTES-1:0] ret_mask,
   output logic                    ret_pre,
   output logic                    cal_stb,
   output logic                    sam_stb,
   output logic                    relax_stb
);
   localparam int BYTES = LANES * LANE_BYTES;

   if (PINS * SLOTS != PKT_W) begin : g_bad_geometry
      $error("col_pkt_engine: PINS*SLOTS must equal the packet width");
   end
   if (BYTES != MASK_W) begin : g_bad_lanes
      $error("col_pkt_engine: LANES*LANE_BYTES must equal the mask width");
   end
   if (DATA_W != BYTES * 8) begin : g_bad_data
      $error("col_pkt_engine: DATA_W must be eight bits per byte lane");
   end

   logic [PKT_W-1:0] pkt;
   logic             pkt_done;
   dec_t             dec;

   cpe_framer #(.PINS(PINS), .SLOTS(SLOTS)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .col_in   (col_in),
      .pkt      (pkt),
      .pkt_done (pkt_done)
   );

   cpe_decode #(.LANES(LANES), .LANE_BYTES(LANE_BYTES)) u_decode (
      .pkt      (pkt),
      .pkt_done (pkt_done),
      .attn     (attn),
      .dev_id   (dev_id),
      .dec      (dec)
   );

   cpe_wbuf #(.DATA_W(DATA_W), .MASK_W(BYTES), .BANK_W(BANK_W), .COL_W(COL_W)) u_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .retire   (dec.retire),
      .load     (dec.load),
      .autopre  (dec.autopre),
      .bank     (dec.bank),
      .col      (dec.col),
      .mask     (dec.mask),
      .wdata    (wdata),
      .ret_stb  (ret_stb),
      .ret_pre  (ret_pre),
      .ret_bank (ret_bank),
      .ret_col  (ret_col),
      .ret_data (ret_data),
      .ret_mask (ret_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_stb    <= 1'b0;
         rd_bank   <= '0;
         rd_col    <= '0;
         pre_stb   <= 1'b0;
         pre_bank  <= '0;
         xpre_stb  <= 1'b0;
         xpre_bank <= '0;
         cal_stb   <= 1'b0;
         sam_stb   <= 1'b0;
         relax_stb <= 1'b0;
      end else begin
         rd_stb    <= dec.rd;
         rd_bank   <= dec.bank;
         rd_col    <= dec.col;
         pre_stb   <= dec.cpre;
         pre_bank  <= dec.bank;
         xpre_stb  <= dec.xpre;
         xpre_bank <= dec.xbank;
         cal_stb   <= dec.cal;
         sam_stb   <= dec.sam;
         relax_stb <= dec.relax;
      end
   end
endmodule

// File: rtl/cpe_chk.sv
module cpe_chk
   import cpe_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              attn,
   input logic              rd_stb,
   input logic [BANK_W-1:0] rd_bank,
   input logic              pre_stb,
   input logic [BANK_W-1:0] pre_bank,
   input logic              xpre_stb,
   input logic              ret_stb,
   input logic              ret_pre,
   input logic              cal_stb,
   input logic              sam_stb,
   input logic              relax_stb
);
   // R1: strobes last a single tick
   p_rd_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb);
   p_ret_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ret_stb |=> !ret_stb);

   // R2: a read to this device never drains the buffer
   p_read_no_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> !ret_stb);

   // R7: read with auto-precharge closes the bank it read
   p_rda_same_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && pre_stb) |-> (pre_bank == rd_bank));

   // R8: close-after-write only rides on an actual retire
   p_retpre_with_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ret_pre |-> ret_stb);

   // R9: sampling only together with calibration
   p_sam_with_cal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sam_stb |-> cal_stb);

   // R11: nothing happens outside the attention state
   p_attn_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || pre_stb || xpre_stb || ret_stb || cal_stb || relax_stb) |-> $past(attn));
endmodule

bind col_pkt_engine cpe_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .attn      (attn),
   .rd_stb    (rd_stb),
   .rd_bank   (rd_bank),
   .pre_stb   (pre_stb),
   .pre_bank  (pre_bank),
   .xpre_stb  (xpre_stb),
   .ret_stb   (ret_stb),
   .ret_pre   (ret_pre),
   .cal_stb   (cal_stb),
   .sam_stb   (sam_stb),
   .relax_stb (relax_stb)
);

// File: tb/col_pkt_engine_tb.sv
`timescale 1ns/1ps
module col_pkt_engine_tb;
   logic         clk = 1'b0;
   logic         rst_n;
   logic [4:0]   col_in;
   logic         attn;
   logic [4:0]   dev_id;
   logic [127:0] wdata;
   logic         rd_stb, pre_stb, xpre_stb, ret_stb, ret_pre, cal_stb, sam_stb, relax_stb;
   logic [4:0]   rd_bank, pre_bank, xpre_bank, ret_bank;
   logic [5:0]   rd_col, ret_col;
   logic [127:0] ret_data;
   logic [15:0]  ret_mask;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] pre_flags;

   always #10 clk = ~clk;

   col_pkt_engine u_dut (
      .clk(clk), .rst_n(rst_n), .col_in(col_in), .attn(attn), .dev_id(dev_id),
      .wdata(wdata), .rd_stb(rd_stb), .rd_bank(rd_bank), .rd_col(rd_col),
      .pre_stb(pre_stb), .pre_bank(pre_bank), .xpre_stb(xpre_stb),
      .xpre_bank(xpre_bank), .ret_stb(ret_stb), .ret_bank(ret_bank),
      .ret_col(ret_col), .ret_data(ret_data), .ret_mask(ret_mask),
      .ret_pre(ret_pre), .cal_stb(cal_stb), .sam_stb(sam_stb), .relax_stb(relax_stb)
   );

   localparam logic [4:0] ME = 5'h0B;
   localparam logic [4:0] OT = 5'h03;

   typedef struct packed {
      logic [4:0]  dev;
      logic [4:0]  bank;
      logic [5:0]  col;
      logic [3:0]  op;
      logic        m;
      logic [15:0] tail;
      logic        att;
      logic [7:0]  exp;   // {rd,pre,xpre,ret,ret_pre,cal,sam,relax}
      logic [3:0]  req;
   } tv_t;

   localparam int NTV = 25;
   localparam tv_t TV [NTV] = '{
      '{ME, 5'h01, 6'h02, 4'h3, 1'b0, 16'h0003, 1'b1, 8'h80, 4'd2 },  // R2 read, empty buffer
      '{ME, 5'h00, 6'h00, 4'h0, 1'b0, 16'h0003, 1'b1, 8'h00, 4'd5 },  // R5 retire on empty
      '{ME, 5'h04, 6'h09, 4'h1, 1'b0, 16'h0003, 1'b1, 8'h00, 4'd4 },  // R4 load write
      '{ME, 5'h01, 6'h02, 4'h3, 1'b0, 16'h0003, 1'b1, 8'h80, 4'd2 },  // R2 read keeps buffer
      '{OT, 5'h00, 6'h00, 4'h3, 1'b0, 16'h0003, 1'b1, 8'h10, 4'd3 },  // R3 other device drains
      '{OT, 5'h00, 6'h00, 4'h0, 1'b0, 16'h0003, 1'b1, 8'h00, 4'd5 },  // R5 empty again
      '{ME, 5'h07, 6'h03, 4'h5, 1'b0, 16'h0003, 1'b1, 8'h00, 4'd8 },  // R8 load with auto-pre
      '{ME, 5'h00, 6'h00, 4'h0, 1'b1, 16'hFFFF, 1'b1, 8'h18, 4'd8 },  // R8 retire + close
      '{ME, 5'h02, 6'h00, 4'h4, 1'b0, 16'h0003, 1'b1, 8'h40, 4'd7 },  // R7 precharge
      '{ME, 5'h05, 6'h01, 4'h7, 1'b0, 16'h0003, 1'b1, 8'hC0, 4'd7 },  // R7 read + precharge
      '{ME, 5'h00, 6'h00, 4'h2, 1'b0, 16'h0003, 1'b1, 8'h00, 4'd12},  // R12 reserved, empty
      '{ME, 5'h06, 6'h06, 4'h1, 1'b0, 16'h0003, 1'b1, 8'h00, 4'd4 },  // R4 load
      '{ME, 5'h00, 6'h00, 4'h6, 1'b0, 16'h0003, 1'b1, 8'h10, 4'd12},  // R12 reserved retires
      '{ME, 5'h01, 6'h01, 4'hB, 1'b0, 16'h0003, 1'b1, 8'h81, 4'd10},  // R10 read + relax
      '{ME, 5'h03, 6'h00, 4'hC, 1'b0, 16'h0003, 1'b1, 8'h41, 4'd10},  // R10 precharge + relax
      '{OT, 5'h00, 6'h00, 4'h0, 1'b0, 16'h406B, 1'b1, 8'h20, 4'd9 },  // R9 extended precharge
      '{OT, 5'h00, 6'h00, 4'h0, 1'b0, 16'h206B, 1'b1, 8'h04, 4'd9 },  // R9 calibrate
      '{OT, 5'h00, 6'h00, 4'h0, 1'b0, 16'h306B, 1'b1, 8'h06, 4'd9 },  // R9 calibrate + sample
      '{OT, 5'h00, 6'h00, 4'h0, 1'b0, 16'h486B, 1'b1, 8'h21, 4'd9 },  // R9 precharge + relax
      '{OT, 5'h00, 6'h00, 4'h0, 1'b0, 16'h746B, 1'b1, 8'h00, 4'd9 },  // R9 reserved bit 0
      '{OT, 5'h00, 6'h00, 4'h0, 1'b0, 16'h4063, 1'b1, 8'h00, 4'd9 },  // R9 other device
      '{ME, 5'h08, 6'h08, 4'h1, 1'b0, 16'h0003, 1'b1, 8'h00, 4'd4 },  // R4 load
      '{ME, 5'h00, 6'h00, 4'h0, 1'b0, 16'h0003, 1'b0, 8'h00, 4'd11},  // R11 ignored retire
      '{ME, 5'h00, 6'h00, 4'h0, 1'b0, 16'h0003, 1'b1, 8'h10, 4'd11},  // R11 buffer survived
      '{ME, 5'h01, 6'h01, 4'h3, 1'b0, 16'h0003, 1'b0, 8'h00, 4'd11}   // R11 ignored read
   };

   function automatic logic [39:0] mkpkt(input logic [4:0] dv, input logic [4:0] bk,
                                         input logic [5:0] cl, input logic [3:0] op,
                                         input logic m, input logic [15:0] tl);
      logic [39:0] v;
      v        = '0;
      v[0]     = 1'b1;
      v[5:1]   = dv;
      v[10:6]  = bk;
      v[16:11] = cl;
      v[20:17] = op;
      v[23]    = m;
      v[39:24] = tl;
      return v;
   endfunction

   function automatic logic [7:0] flags();
      return {rd_stb, pre_stb, xpre_stb, ret_stb, ret_pre, cal_stb, sam_stb, relax_stb};
   endfunction

   task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the decode edge
   task automatic send(input logic [39:0] v, input logic a, input logic [127:0] wd);
      for (int s = 0; s < 8; s++) begin
         col_in = v[s*5 +: 5];
         attn   = a;
         @(negedge clk);
      end
      pre_flags = flags();
      col_in    = '0;
      wdata     = wd;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      rst_n  = 1'b0;
      col_in = '0;
      attn   = 1'b1;
      dev_id = ME;
      wdata  = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R5 reset strobes", 128'(flags()), 128'h0);
      chk("R5 reset ret_data", ret_data, 128'h0);

      for (int i = 0; i < NTV; i++) begin
         send(mkpkt(TV[i].dev, TV[i].bank, TV[i].col, TV[i].op, TV[i].m, TV[i].tail),
              TV[i].att, {4{32'hA500_0000 | 32'(i)}});
         chk($sformatf("R%0d vector %0d flags", TV[i].req, i), 128'(flags()), 128'(TV[i].exp));
      end

      // R1: pin 0 high inside the packet (bank bit 4) must not re-frame; quiet before decode edge
      send(mkpkt(ME, 5'h11, 6'h2A, 4'h3, 1'b0, 16'h0003), 1'b1, '0);
      chk("R1 no strobe before decode edge", 128'(pre_flags), 128'h0);
      chk("R2 rd_stb", 128'(rd_stb), 128'h1);
      chk("R2 rd_bank", 128'(rd_bank), 128'h11);
      chk("R2 rd_col", 128'(rd_col), 128'h2A);
      @(negedge clk);
      chk("R1 strobe lasts one tick", 128'(rd_stb), 128'h0);

      // R4 ordering and R6 late mask
      send(mkpkt(ME, 5'h11, 6'h2A, 4'h1, 1'b0, 16'h0003), 1'b1, {4{32'h1111_2222}});
      send(mkpkt(ME, 5'h12, 6'h15, 4'h1, 1'b0, 16'h0003), 1'b1, {4{32'h3333_4444}});
      chk("R4 old entry retired", 128'(ret_stb), 128'h1);
      chk("R4 ret_bank old", 128'(ret_bank), 128'h11);
      chk("R4 ret_col old", 128'(ret_col), 128'h2A);
      chk("R4 ret_data old", ret_data, {4{32'h1111_2222}});
      chk("R6 mask all ones without mask packet", 128'(ret_mask), 128'hFFFF);
      send(mkpkt(OT, 5'h00, 6'h00, 4'h0, 1'b1, 16'hC35A), 1'b1, '0);
      chk("R4 ret_data new", ret_data, {4{32'h3333_4444}});
      chk("R6 lane masks from mask packet", 128'(ret_mask), 128'hC35A);
      chk("R4 ret_bank new", 128'(ret_bank), 128'h12);

      // R7 and R9 bank fields
      send(mkpkt(ME, 5'h1D, 6'h00, 4'h4, 1'b0, 16'h0003), 1'b1, '0);
      chk("R7 pre_bank", 128'({pre_stb, pre_bank}), 128'h3D);
      send(mkpkt(OT, 5'h00, 6'h00, 4'h0, 1'b0, 16'h42CB), 1'b1, '0);
      chk("R9 xpre_bank", 128'({xpre_stb, xpre_bank}), 128'h36);

      // R8 bank to close
      send(mkpkt(ME, 5'h09, 6'h04, 4'h5, 1'b0, 16'h0003), 1'b1, {4{32'h5555_6666}});
      send(mkpkt(ME, 5'h00, 6'h00, 4'h0, 1'b0, 16'h0003), 1'b1, '0);
      chk("R8 ret_pre with bank", 128'({ret_pre, ret_bank}), 128'h29);

      // R5 reset empties a full buffer
      send(mkpkt(ME, 5'h02, 6'h02, 4'h1, 1'b0, 16'h0003), 1'b1, {4{32'h7777_8888}});
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      send(mkpkt(ME, 5'h00, 6'h00, 4'h0, 1'b0, 16'h0003), 1'b1, '0);
      chk("R5 no retire after reset", 128'(ret_stb), 128'h0);

      finish_run();
   end
endmodule